// File: doc/BRIEF.md
# Sequential Signed Word Divider with Data-Dependent Latency

The block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor. It returns a 16-bit signed quotient, a 16-bit signed remainder, an overflow flag, a divide-by-zero flag and the number of clock cycles the operation took. The latency is not fixed. It depends on the operand signs and on how many zero bits the magnitude of the quotient holds, so the block keeps the exact timing of an older microcoded divide step. A host that has to stay in lock-step with that timing can stall on `busy_o` and needs no separate timing model.

The core works on magnitudes. It runs a 16-step restoring division and then fixes the signs. The quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. If the upper half of the dividend magnitude is already at least the divisor magnitude, the block takes a short exit and does not divide. A zero divisor is reported in the cycle after the request.

Top module: `sdiv_timed`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `quot_o`, `rem_o`, `ovf_o`, `dbz_o` and `cycles_o` are all zero.
- R2: A request is accepted on a clock edge where `start_i` is high and both `busy_o` and `done_o` are low. The operands are captured at that edge. A `start_i` pulse, or an operand change, while `busy_o` is high has no effect on the result that is in progress.
- R3: A zero divisor does not raise `busy_o`. `done_o` rises at the edge after acceptance, with `dbz_o`=1, `cycles_o`=0, `quot_o`=0, `rem_o`=0 and `ovf_o`=0.
- R4: Absolute overflow occurs when bits 31..16 of the dividend magnitude are greater than or equal to the divisor magnitude. The operation then takes 16 cycles for a non-negative dividend and 18 for a negative one, and reports `ovf_o`=1 with `quot_o`=0 and `rem_o`=0.
- R5: Without absolute overflow, `quot_o` is the truncated magnitude quotient, negated when the operand signs differ. `rem_o` is the magnitude remainder with the sign of the dividend.
- R6: Without absolute overflow, the latency is twice P. P is the sum of two terms: a base of 60 (both operands non-negative), 63 (negative dividend, non-negative divisor), 61 (non-negative dividend, negative divisor) or 62 (both negative), plus the number of zero bits among bits 15..1 of the 16-bit magnitude quotient.
- R7: Signed overflow is the case where the magnitude fits but the signed quotient lies outside -32768..32767. It uses the full-length path of R6 and sets `ovf_o`=1 at completion. `quot_o` and `rem_o` then carry the low 16 bits of the signed results.
- R8: `busy_o` stays high for exactly `cycles_o` clock cycles. `done_o` is a one-cycle pulse in the cycle after `busy_o` falls and is never high together with `busy_o`. All result outputs hold until the next completion.
- R9: A completion with no overflow and a non-zero divisor reports an even count from 122 to 156. The count of 120 occurs only with signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a division |
| dividend_i | input | 32 | Signed dividend |
| divisor_i | input | 16 | Signed divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Signed quotient |
| rem_o | output | 16 | Signed remainder |
| ovf_o | output | 1 | Absolute or signed overflow |
| dbz_o | output | 1 | Divisor was zero |
| cycles_o | output | 8 | Busy cycles taken by the last operation |

## Verification
On every cycle the assertions check the shape of the handshake: `done_o` never coincides with `busy_o`, it lasts a single cycle, and it follows every fall of `busy_o`. They also check that captured operands stay frozen while the block is busy, and that every completion reports a count and flag pattern that is legal for its class: zero for divide-by-zero, 16 or 18 for the short exit, and an even count from 122 to 156 for a clean result. Only the bench's scenarios can show that a given count is the right one for given operands, that quotient and remainder values and signs are correct, and that a request made while busy is really ignored. The bench sweeps many divisors against structured and pseudo-random dividends and computes every expected value arithmetically.

// File: rtl/sdiv_timed.sv
module sdiv_timed (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] dividend_i,
  input  logic [15:0] divisor_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] quot_o,
  output logic [15:0] rem_o,
  output logic        ovf_o,
  output logic        dbz_o,
  output logic [7:0]  cycles_o
);

  localparam int QW = 16;
  localparam int DW = 2 * QW;
  localparam int CW = 8;
  localparam int PW = 7;

  logic          dividing_q, short_q, negq_q, negr_q;
  logic [CW-1:0] step_q, tgt_q;
  logic [PW-1:0] base_q;
  logic [QW-1:0] mdvs_q, rem_q, qsh_q;

  wire          neg_d  = dividend_i[DW-1];
  wire          neg_v  = divisor_i[QW-1];
  wire [DW-1:0] mag_d  = neg_d ? (~dividend_i + 1'b1) : dividend_i;
  wire [QW-1:0] mag_v  = neg_v ? (~divisor_i + 1'b1) : divisor_i;
  wire          absovf = mag_d[DW-1:QW] >= mag_v;
  wire          accept = start_i && !busy_o && !done_o;

  wire [PW-1:0] base_n = neg_v ? (neg_d ? PW'(62) : PW'(61))
                               : (neg_d ? PW'(63) : PW'(60));
  wire [CW-1:0] short_cyc = neg_d ? CW'(18) : CW'(16);

  wire [QW:0]   trial = {rem_q, qsh_q[QW-1]};
  wire          ge    = trial >= {1'b0, mdvs_q};
  wire [QW:0]   diff  = trial - {1'b0, mdvs_q};
  wire [QW-1:0] rem_n = ge ? diff[QW-1:0] : trial[QW-1:0];
  wire [QW-1:0] qsh_n = {qsh_q[QW-2:0], ge};

  function automatic logic [PW-1:0] zero_count(input logic [QW-1:0] q);
    logic [PW-1:0] z;
    z = '0;
    for (int i = 1; i < QW; i++)
      if (!q[i]) z = z + 1'b1;
    return z;
  endfunction

  wire [PW-1:0] pairs = base_q + zero_count(qsh_n);
  wire [CW-1:0] tgt_n = {pairs, 1'b0};

  wire [QW-1:0] q_signed = negq_q ? (~qsh_q + 1'b1) : qsh_q;
  wire [QW-1:0] r_signed = negr_q ? (~rem_q + 1'b1) : rem_q;
  wire          sovf     = negq_q ? (qsh_q > 16'h8000) : qsh_q[QW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      quot_o     <= '0;
      rem_o      <= '0;
      ovf_o      <= 1'b0;
      dbz_o      <= 1'b0;
      cycles_o   <= '0;
      dividing_q <= 1'b0;
      short_q    <= 1'b0;
      negq_q     <= 1'b0;
      negr_q     <= 1'b0;
      step_q     <= '0;
      tgt_q      <= '0;
      base_q     <= '0;
      mdvs_q     <= '0;
      rem_q      <= '0;
      qsh_q      <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        if (divisor_i == '0) begin
          done_o   <= 1'b1;
          dbz_o    <= 1'b1;
          ovf_o    <= 1'b0;
          quot_o   <= '0;
          rem_o    <= '0;
          cycles_o <= '0;
        end else begin
          busy_o     <= 1'b1;
          step_q     <= CW'(1);
          dividing_q <= !absovf;
          short_q    <= absovf;
          tgt_q      <= absovf ? short_cyc : '0;
          base_q     <= base_n;
          mdvs_q     <= mag_v;
          rem_q      <= mag_d[DW-1:QW];
          qsh_q      <= mag_d[QW-1:0];
          negq_q     <= neg_d ^ neg_v;
          negr_q     <= neg_d;
        end
      end else if (busy_o) begin
        step_q <= step_q + 1'b1;
        if (dividing_q) begin
          rem_q <= rem_n;
          qsh_q <= qsh_n;
          if (step_q == CW'(QW)) begin
            dividing_q <= 1'b0;
            tgt_q      <= tgt_n;
          end
        end else if (step_q == tgt_q) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          dbz_o    <= 1'b0;
          cycles_o <= tgt_q;
          ovf_o    <= short_q | sovf;
          quot_o   <= short_q ? '0 : q_signed;
          rem_o    <= short_q ? '0 : r_signed;
        end
      end
    end
  end

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_fall_gives_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  assert_operands_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mdvs_q) && $stable(negq_q) && $stable(negr_q));
  assert_dbz_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && dbz_o |-> cycles_o == '0 && quot_o == '0 && rem_o == '0 && !ovf_o);
  assert_short_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && ovf_o && cycles_o < CW'(120) |-> (cycles_o == CW'(16) || cycles_o == CW'(18))
      && quot_o == '0 && rem_o == '0);
  assert_clean_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !dbz_o && !ovf_o |-> cycles_o >= CW'(122) && cycles_o <= CW'(156) && !cycles_o[0]);

endmodule

// File: tb/sdiv_timed_tb.sv
`timescale 1ns/1ps
module sdiv_timed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic        busy_o, done_o, ovf_o, dbz_o;
  logic [15:0] quot_o, rem_o;
  logic [7:0]  cycles_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  sdiv_timed u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
    .rem_o(rem_o), .ovf_o(ovf_o), .dbz_o(dbz_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [15:0] b, input bit poke);
    longint sa, sb, ma, mb, qm, rm, q, r;
    int exp_cyc, pairs, z, n, guard;
    bit exp_ovf, exp_dbz, shortp;
    logic [15:0] exp_q, exp_r;
    string tc, tv, to;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ma = sa < 0 ? -sa : sa;
    mb = sb < 0 ? -sb : sb;
    exp_dbz = (sb == 0);
    shortp = 0;
    exp_ovf = 0; exp_q = '0; exp_r = '0; exp_cyc = 0;
    tc = "R6"; tv = "R5"; to = "R7";
    if (exp_dbz) begin
      tc = "R3"; tv = "R3"; to = "R3";
    end else if ((ma >> 16) >= mb) begin
      shortp = 1; exp_ovf = 1;
      exp_cyc = sa < 0 ? 18 : 16;
      tc = "R4"; tv = "R4"; to = "R4";
    end else begin
      qm = ma / mb; rm = ma % mb;
      z = 0;
      for (int i = 1; i < 16; i++) if (((qm >> i) & 1) == 0) z++;
      if (sb >= 0) pairs = sa >= 0 ? 60 : 63;
      else         pairs = sa >= 0 ? 61 : 62;
      exp_cyc = 2 * (pairs + z);
      q = ((sa < 0) != (sb < 0)) ? -qm : qm;
      r = sa < 0 ? -rm : rm;
      exp_ovf = (q < -32768) || (q > 32767);
      exp_q = q[15:0];
      exp_r = r[15:0];
    end
    @(negedge clk);
    dividend_i = a; divisor_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; dividend_i = ~a; divisor_i = ~b;
    n = 0; guard = 0;
    while (!done_o && guard < 400) begin
      chk(!(done_o && busy_o), "R8 overlap", 1, 0);
      if (busy_o) n++;
      if (poke && n == 5) begin
        start_i = 1'b1; dividend_i = rnd(); divisor_i = 16'h0001;
      end else start_i = 1'b0;
      @(negedge clk);
      guard++;
    end
    start_i = 1'b0;
    chk(done_o == 1'b1, "R8 done seen", done_o, 1);
    chk(n == exp_cyc, {tc, " busy cycles"}, n, exp_cyc);
    chk(cycles_o == 8'(exp_cyc), {tc, " cycles_o"}, cycles_o, exp_cyc);
    chk(dbz_o == exp_dbz, "R3 dbz flag", dbz_o, exp_dbz);
    chk(ovf_o == exp_ovf, {to, " ovf flag"}, ovf_o, exp_ovf);
    chk(quot_o == exp_q, {poke ? "R2" : tv, " quotient"}, quot_o, exp_q);
    chk(rem_o == exp_r, {poke ? "R2" : tv, " remainder"}, rem_o, exp_r);
    if (!exp_dbz && !exp_ovf)
      chk(exp_cyc >= 122 && exp_cyc <= 156, "R9 clean range", exp_cyc, 122);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R8 pulse ends", done_o, 0);
    chk(quot_o == exp_q && rem_o == exp_r, "R8 hold", quot_o, exp_q);
  endtask

  function automatic logic [15:0] pick_div(input int k);
    case (k)
      0: return 16'h0001;  1: return 16'hFFFF;  2: return 16'h0002;
      3: return 16'hFFFE;  4: return 16'h0003;  5: return 16'h7FFF;
      6: return 16'h8000;  7: return 16'h8001;  8: return 16'h00FF;
      9: return 16'hFF00;  default: return rnd() [15:0] | 16'h0001;
    endcase
  endfunction

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] b, mb;
    logic [31:0] a, r1;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R1 handshake", busy_o, 0);
    chk(quot_o == 0 && rem_o == 0 && cycles_o == 0 && !ovf_o && !dbz_o, "R1 results", quot_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'd1234, 16'h0000, 0);
    run_op(32'h8000_0000, 16'h0000, 0);
    run_op(32'h0001_0000, 16'h0001, 0);
    run_op(32'hFFFF_0000, 16'h0001, 0);
    run_op(32'h8000_0000, 16'hFFFF, 0);
    run_op(32'hFFFF_FFFF, 16'h0002, 0);
    run_op(32'h7FFE_8001, 16'h7FFF, 0);
    run_op(32'h3FFF_0001, 16'h7FFF, 0);
    run_op(32'h0000_8000, 16'hFFFF, 0);
    run_op(32'h0000_8000, 16'h0001, 0);
    run_op(32'hFFFF_8000, 16'h0001, 0);
    run_op(32'd100, 16'h0007, 1);
    run_op(32'hFFFF_F000, 16'hFFF3, 1);

    for (int k = 0; k < 40; k++) begin
      b = pick_div(k);
      mb = b[15] ? ~b + 1'b1 : b;
      for (int j = 0; j < 14; j++) begin
        r1 = rnd();
        case (j % 3)
          0: a = rnd();
          1: a = 32'(mb) * 32'(r1[15:0]) + 32'(rnd() % {16'h0, mb});
          default: a = {{12{r1[19]}}, r1[19:0]};
        endcase
        if (j % 3 == 1 && r1[16]) a = ~a + 1'b1;
        run_op(a, b, j == 7);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule